// File: doc/BRIEF.md
# DMA Request Router with Grouped Priority Arbiter

This block sits between the peripherals of a chip and a bank of DMA channels that share one bus. Every peripheral request line owns a small map register that says whether the line is connected and, if so, to which channel. The request lines are folded into one pending bit per channel. An arbiter then hands the single bus grant to one channel at a time.

The arbiter ranks channels in four priority levels taken from channel index bits 3:2. Channels 16 apart therefore share a level: level 0 holds channels 0-3 and 16-19, and level 3 holds channels 12-15 and 28-31. Within a level, the turn rotates. Once a channel holds the grant, it keeps it for as long as it signals activity, so no transfer is cut off partway. Software loads the map through a simple write port with a combinational read-back. The map address is the line number itself: address bit 6 selects the bank, with lines 0-63 in the first bank and the rest in the second, and bits 5:0 give the line within the bank.

Top module: `dma_req_router`

## Requirements
- R1: A map register write stores bit 7 as the valid flag and bits 4:0 as the target channel. Bits 6:5 are not stored. A read returns {valid, 2'b00, channel} combinationally for the addressed line.
- R2: The map address is {bank, index}, with cfg_addr[6] as the bank and cfg_addr[5:0] as the index, so the line number is bank*64+index. A write to a line number of NUM_REQ or above is ignored, and a read of such a line returns zero.
- R3: Writing zero to a map register removes the mapping. After that, the line sets no channel's pending bit.
- R4: ch_pend[c] is the OR of every asserted request line whose valid mapping selects channel c. It is registered, so it shows one clock edge after the request is sampled. A line whose valid flag is 0 sets no pending bit.
- R5: Two or more lines mapped to the same channel merge into that channel's single pending bit, and no error is raised.
- R6: grant is one-hot or zero. When no grant is held, a channel with pending and ready both set gets the grant at the next clock edge. A grant only goes to such a channel.
- R7: A new grant goes to the candidate channel in the lowest-numbered non-empty priority level. The level of channel c is c[3:2].
- R8: Within a level, the turn rotates. The search starts after the last channel granted in that level and proceeds in rising channel index, wrapping around. After reset, the lowest index of each level comes first.
- R9: A grant is held while the granted channel's ch_active is 1, and it is not preempted by any request, including one from a higher level. At the edge where ch_active is 0, the grant clears, and the next grant can come at the following edge.
- R10: After reset, every map register reads zero, and ch_pend and grant are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Map register write strobe |
| cfg_addr | input | 7 | Map line address {bank, index} |
| cfg_wdata | input | 8 | Write data: bit 7 valid, bits 4:0 channel |
| cfg_rdata | output | 8 | Read data for the addressed line |
| periph_req | input | NUM_REQ | Peripheral request lines |
| ch_ready | input | NUM_CH | Channel can accept a grant |
| ch_active | input | NUM_CH | Granted channel is still transferring |
| ch_pend | output | NUM_CH | Registered per-channel request pending |
| grant | output | NUM_CH | One-hot bus grant |

## Verification
Map writes take effect at the write edge, and reads are combinational, so read-back is sampled on the falling edge after the write. A request driven before edge N shows on ch_pend after edge N. If the arbiter is idle, grant shows after edge N+1. The bench samples exactly those falling edges and also checks that ch_pend is still low before edge N. A release needs one edge to clear the grant and one more to issue the next, and the hold test samples grant zero and then the new winner on those two successive falling edges.

// File: rtl/reqmap_pkg.sv
package reqmap_pkg;
    localparam int CH_IDX_W   = 5;
    localparam int BANK_LINES = 64;
    localparam int ADDR_W     = 7;
    localparam int DATA_W     = 8;
    localparam int VALID_POS  = 7;
    localparam int LEVELS     = 4;

    typedef logic [CH_IDX_W-1:0] ch_idx_t;

    typedef struct packed {
        logic    valid;
        ch_idx_t chan;
    } map_entry_t;

    function automatic logic [1:0] level_of(input ch_idx_t ch);
        return ch[3:2];
    endfunction
endpackage

// File: rtl/reqmap_regs.sv
module reqmap_regs
    import reqmap_pkg::*;
#(
    parameter int NUM_REQ = 80
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cfg_we,
    input  logic [ADDR_W-1:0]          cfg_addr,
    input  logic [DATA_W-1:0]          cfg_wdata,
    output logic [DATA_W-1:0]          cfg_rdata,
    output map_entry_t [NUM_REQ-1:0]   map_o
);
    typedef struct packed {
        map_entry_t [NUM_REQ-1:0] map;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        cfg_rdata = '0;
        for (int i = 0; i < NUM_REQ; i++) begin
            if (cfg_addr == ADDR_W'(i)) begin
                cfg_rdata = {st_q.map[i].valid, 2'b00, st_q.map[i].chan};
                if (cfg_we) begin
                    st_d.map[i].valid = cfg_wdata[VALID_POS];
                    st_d.map[i].chan  = cfg_wdata[CH_IDX_W-1:0];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign map_o = st_q.map;

    for (genvar g = 0; g < NUM_REQ; g++) begin : g_chk
        assert_map_write_R1 : assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_we && cfg_addr == ADDR_W'(g)) |=>
            (st_q.map[g].valid == $past(cfg_wdata[VALID_POS]) &&
             st_q.map[g].chan  == $past(cfg_wdata[CH_IDX_W-1:0])));
    end
endmodule

// File: rtl/reqmap_fanin.sv
module reqmap_fanin
    import reqmap_pkg::*;
#(
    parameter int NUM_REQ = 80,
    parameter int NUM_CH  = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  map_entry_t [NUM_REQ-1:0] map_i,
    input  logic [NUM_REQ-1:0]       periph_req,
    output logic [NUM_CH-1:0]        pend_o
);
    typedef struct packed {
        logic [NUM_CH-1:0] pend;
    } state_t;

    state_t st_d, st_q;
    logic   any_valid;

    always_comb begin
        st_d      = '0;
        any_valid = 1'b0;
        for (int l = 0; l < NUM_REQ; l++) begin
            any_valid = any_valid | map_i[l].valid;
        end
        for (int c = 0; c < NUM_CH; c++) begin
            for (int l = 0; l < NUM_REQ; l++) begin
                if (periph_req[l] && map_i[l].valid && map_i[l].chan == CH_IDX_W'(c)) begin
                    st_d.pend[c] = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend_o = st_q.pend;

    assert_unmapped_quiet_R3 : assert property (@(posedge clk) disable iff (!rst_n)
        (!any_valid) |=> (pend_o == '0));
    assert_no_request_quiet_R4 : assert property (@(posedge clk) disable iff (!rst_n)
        (periph_req == '0) |=> (pend_o == '0));
endmodule

// File: rtl/reqmap_arb.sv
module reqmap_arb
    import reqmap_pkg::*;
#(
    parameter int NUM_CH = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] cand,
    input  logic [NUM_CH-1:0] ch_active,
    output logic [NUM_CH-1:0] grant
);
    typedef struct packed {
        logic    [NUM_CH-1:0]  grant;
        ch_idx_t [LEVELS-1:0]  last;
    } state_t;

    localparam state_t RST = '{grant: '0, last: {LEVELS{CH_IDX_W'(NUM_CH-1)}}};

    state_t st_d, st_q;
    logic   found;
    int     win;
    int     idx;

    always_comb begin
        st_d  = st_q;
        found = 1'b0;
        win   = 0;
        idx   = 0;
        if (st_q.grant != '0) begin
            if ((st_q.grant & ch_active) == '0) st_d.grant = '0;
        end else if (cand != '0) begin
            for (int g = 0; g < LEVELS; g++) begin
                for (int k = 1; k <= NUM_CH; k++) begin
                    idx = (int'(st_q.last[g]) + k) % NUM_CH;
                    if (!found && level_of(CH_IDX_W'(idx)) == 2'(g) && cand[idx]) begin
                        found = 1'b1;
                        win   = idx;
                    end
                end
            end
            st_d.grant = NUM_CH'(1) << win;
            st_d.last[level_of(CH_IDX_W'(win))] = CH_IDX_W'(win);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RST;
        else        st_q <= st_d;
    end

    assign grant = st_q.grant;

    assert_grant_onehot_R6 : assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));
    assert_idle_grants_R6 : assert property (@(posedge clk) disable iff (!rst_n)
        (grant == '0 && cand != '0) |=> (grant != '0));
    assert_grant_legal_R6 : assert property (@(posedge clk) disable iff (!rst_n)
        (grant == '0) |=> (grant == '0 || (grant & $past(cand)) != '0));
    assert_grant_hold_R9 : assert property (@(posedge clk) disable iff (!rst_n)
        (grant != '0 && (grant & ch_active) != '0) |=> (grant == $past(grant)));
    assert_grant_release_R9 : assert property (@(posedge clk) disable iff (!rst_n)
        (grant != '0 && (grant & ch_active) == '0) |=> (grant == '0));
endmodule

// File: rtl/dma_req_router.sv
module dma_req_router
    import reqmap_pkg::*;
#(
    parameter int NUM_REQ = 80,
    parameter int NUM_CH  = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [6:0]         cfg_addr,
    input  logic [7:0]         cfg_wdata,
    output logic [7:0]         cfg_rdata,
    input  logic [NUM_REQ-1:0] periph_req,
    input  logic [NUM_CH-1:0]  ch_ready,
    input  logic [NUM_CH-1:0]  ch_active,
    output logic [NUM_CH-1:0]  ch_pend,
    output logic [NUM_CH-1:0]  grant
);
    map_entry_t [NUM_REQ-1:0] map;
    logic [NUM_CH-1:0]        cand;

    reqmap_regs #(.NUM_REQ(NUM_REQ)) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .map_o(map)
    );

    reqmap_fanin #(.NUM_REQ(NUM_REQ), .NUM_CH(NUM_CH)) u_fanin (
        .clk(clk), .rst_n(rst_n), .map_i(map), .periph_req(periph_req), .pend_o(ch_pend)
    );

    assign cand = ch_pend & ch_ready;

    reqmap_arb #(.NUM_CH(NUM_CH)) u_arb (
        .clk(clk), .rst_n(rst_n), .cand(cand), .ch_active(ch_active), .grant(grant)
    );
endmodule

// File: tb/test_dma_req_router.sv
module test_dma_req_router;
    localparam int CLK_PERIOD = 10;
    localparam int NREQ = 80;
    localparam int NCH  = 32;
    localparam int NVEC = 15;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cfg_we = 1'b0;
    logic [6:0]      cfg_addr = '0;
    logic [7:0]      cfg_wdata = '0;
    logic [7:0]      cfg_rdata;
    logic [NREQ-1:0] periph_req = '0;
    logic [NCH-1:0]  ch_ready = '1;
    logic [NCH-1:0]  ch_active = '0;
    logic [NCH-1:0]  ch_pend;
    logic [NCH-1:0]  grant;

    int n_chk = 0;
    int n_bad = 0;

    // {request lines 31:0, ready, expected grant}
    localparam logic [95:0] VEC [NVEC] = '{
        {32'h0000_1000, 32'hFFFF_FFFF, 32'h0000_1000},
        {32'h0000_1100, 32'hFFFF_FFFF, 32'h0000_0100},
        {32'h0000_1110, 32'hFFFF_FFFF, 32'h0000_0010},
        {32'h0000_0011, 32'hFFFF_FFFF, 32'h0000_0001},
        {32'h1001_0000, 32'hFFFF_FFFF, 32'h0001_0000},
        {32'h0001_0001, 32'hFFFF_FFFF, 32'h0000_0001},
        {32'h0001_0001, 32'hFFFF_FFFF, 32'h0001_0000},
        {32'h0002_000A, 32'hFFFF_FFFF, 32'h0002_0000},
        {32'h0002_000A, 32'hFFFF_FFFF, 32'h0000_0002},
        {32'h0002_000A, 32'hFFFF_FFFF, 32'h0000_0008},
        {32'h2000_2000, 32'hFFFF_FFFF, 32'h0000_2000},
        {32'h2000_2000, 32'hFFFF_FFFF, 32'h2000_0000},
        {32'h8800_0000, 32'hFFFF_FFFF, 32'h0800_0000},
        {32'h0000_0000, 32'hFFFF_FFFF, 32'h0000_0000},
        {32'h0000_0011, 32'hFFFF_FFFE, 32'h0000_0010}
    };

    dma_req_router #(.NUM_REQ(NREQ), .NUM_CH(NCH)) i_dma_req_router (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .periph_req(periph_req),
        .ch_ready(ch_ready), .ch_active(ch_active), .ch_pend(ch_pend), .grant(grant)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wait_neg(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic map_write(input logic [6:0] a, input logic [7:0] d);
        cfg_addr  = a;
        cfg_wdata = d;
        cfg_we    = 1'b1;
        wait_neg(1);
        cfg_we    = 1'b0;
    endtask

    task automatic map_read(input string req, input logic [6:0] a, input logic [7:0] exp);
        cfg_addr = a;
        #1;
        check(req, {24'h0, cfg_rdata}, {24'h0, exp});
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        wait_neg(2);
        // R10: reset state
        check("R10 grant", grant, '0);
        check("R10 pend", ch_pend, '0);
        map_read("R10 map", 7'd7, 8'h00);
        rst_n = 1'b1;
        wait_neg(1);

        // R1: format and unused bits
        map_write(7'd5, 8'hE5);
        map_read("R1 readback", 7'd5, 8'h85);

        // identity mapping of lines 0..31
        for (int i = 0; i < 32; i++) map_write(7'(i), 8'h80 | 8'(i));

        // R4: registered pending
        periph_req[5] = 1'b1;
        #1;
        check("R4 pend before edge", ch_pend, '0);
        wait_neg(1);
        check("R4 pend after edge", ch_pend, 32'h20);
        periph_req = '0;
        ch_ready = '0;
        wait_neg(3);
        ch_ready = '1;

        // R6 R7 R8: vector table
        for (int v = 0; v < NVEC; v++) begin
            periph_req[31:0] = VEC[v][95:64];
            ch_ready         = VEC[v][63:32];
            wait_neg(1);
            check("R4 vector pend", ch_pend, VEC[v][95:64]);
            wait_neg(1);
            check("R6 R7 R8 vector grant", grant, VEC[v][31:0]);
            periph_req = '0;
            wait_neg(3);
        end
        ch_ready = '1;

        // R2: second bank, out-of-range line
        map_write({1'b1, 6'd3}, 8'h89);
        map_read("R2 bank1 readback", {1'b1, 6'd3}, 8'h89);
        map_write({1'b1, 6'd20}, 8'h85);
        map_read("R2 out of range", {1'b1, 6'd20}, 8'h00);
        ch_ready = '0;
        periph_req[67] = 1'b1;
        wait_neg(1);
        check("R2 bank1 pend", ch_pend, 32'h200);
        periph_req = '0;
        wait_neg(2);

        // R3: clearing removes the mapping
        map_write({1'b1, 6'd3}, 8'h00);
        map_read("R3 cleared", {1'b1, 6'd3}, 8'h00);
        periph_req[67] = 1'b1;
        wait_neg(2);
        check("R3 no pend", ch_pend, '0);
        periph_req = '0;

        // R4: invalid mapping drives nothing
        map_write(7'd42, 8'h05);
        periph_req[42] = 1'b1;
        wait_neg(2);
        check("R4 invalid map", ch_pend, '0);
        periph_req = '0;

        // R5: merge onto one channel
        map_write(7'd40, 8'h96);
        map_write(7'd41, 8'h96);
        periph_req[41] = 1'b1;
        wait_neg(1);
        check("R5 one line", ch_pend, 32'h0040_0000);
        periph_req[40] = 1'b1;
        wait_neg(1);
        check("R5 both lines", ch_pend, 32'h0040_0000);
        periph_req = '0;
        wait_neg(2);
        ch_ready = '1;

        // R9: hold without preemption
        periph_req[0]  = 1'b1;
        periph_req[12] = 1'b1;
        wait_neg(2);
        check("R9 first grant", grant, 32'h1);
        ch_active[0]   = 1'b1;
        periph_req[0]  = 1'b0;
        periph_req[16] = 1'b1;
        for (int k = 0; k < 4; k++) begin
            wait_neg(1);
            check("R9 held", grant, 32'h1);
        end
        ch_active[0]   = 1'b0;
        periph_req[16] = 1'b0;
        wait_neg(1);
        check("R9 released", grant, '0);
        wait_neg(1);
        check("R9 next grant", grant, 32'h1000);
        periph_req = '0;
        wait_neg(3);
        check("R9 idle", grant, '0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule